// File: doc/BRIEF.md
# Sampling Converter Parallel Bus Model

A synthesizable, clocked model of the digital side of a successive-approximation converter with a parallel result bus. It serves as a bus-functional partner when a host controller is tested. A falling convert-start edge begins a conversion. The model then holds busy high for a programmed number of model-clock cycles. At the end of that time it captures the word presented on `sample_in` as the new result. No analog conversion and no reference are modelled.

The host reads the stored result over an 18-bit bus. The bus is enabled only while chip-select and read are both low. Two select lines fold slices of the result onto narrower lanes, so that 8-bit and 16-bit hosts can gather the word over several reads. Bus positions that carry no data drive ones. A conversion can be cancelled inside a timed window. The host cancels it either with a second convert-start edge while chip-select is low, or with a chip-select falling edge. A cancelled conversion keeps the previous result.

All delays are whole cycles of the model clock. In the requirements, a falling edge means the input is sampled 1 at one rising clock edge and 0 at the next. "Elapsed j" means the edge that detects an event is the j-th clock edge after the edge that detected the start.

Top module: `adc_bus_model`

## Requirements
- R1: After reset, `busy` and `bus_en` are 0 and the stored result is zero, so a full-word read returns 0.
- R2: A falling edge of `conv_n` detected while idle sets `busy` at that same clock edge. `busy` then stays high for exactly CONV_CYC cycles unless the conversion is aborted.
- R3: At the edge that ends a conversion, the value on `sample_in` becomes the stored result, and later reads return it. Values on `sample_in` earlier in the conversion are not stored.
- R4: `bus_en` is 1 in the cycle after an edge that samples `sel_n` and `rd_n` both low, and 0 after any edge where either is high.
- R5: With `size_sel`=0 and `byte_sel`=0, `bus_q[17:0]` is the full result D[17:0].
- R6: With `size_sel`=0 and `byte_sel`=1, `bus_q[17:10]` carries D[9:2] and `bus_q[9:0]` are all ones.
- R7: With `size_sel`=1, D[1:0] appear on `bus_q[11:10]` when `byte_sel`=1 and on `bus_q[3:2]` when `byte_sel`=0. Every other bit is one.
- R8: While the bus is enabled, a change of `byte_sel` or `size_sel` shows on `bus_q` one cycle later.
- R9: A `conv_n` falling edge while `sel_n` is low, at elapsed j with ABORT_MIN <= j <= ABORT_MAX, clears `busy` at that edge, so `busy` was high for j cycles. The stored result is left unchanged.
- R10: A `sel_n` falling edge at elapsed j inside the same window aborts the conversion in the same way and keeps the stored result.
- R11: Abort edges at elapsed j below ABORT_MIN or above ABORT_MAX are ignored. The conversion runs its full length and stores `sample_in`.
- R12: A `conv_n` falling edge during a conversion while `sel_n` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_n | input | 1 | Convert start, active on falling edge |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| byte_sel | input | 1 | Lane select for narrow reads |
| size_sel | input | 1 | Picks the two-LSB transfer |
| sample_in | input | 18 | Word captured when a conversion ends |
| busy | output | 1 | High while a conversion runs |
| bus_q | output | 18 | Result bus data |
| bus_en | output | 1 | Bus drive enable (low means high impedance) |

## Verification
The checker assumes that every low pulse on `conv_n` lasts at least MIN_PULSE cycles, and it flags any shorter one. It also assumes that `sample_in` and the select lines are plain synchronous inputs with no glitches between clock edges. The stimulus always holds `conv_n` low for six cycles. It drives every input on the falling clock edge. It places abort edges at chosen elapsed counts: random ones inside the window, plus directed ones just below it, just above it, and exactly on both bounds.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

   localparam int unsigned BUS_W = 18;

   // lane selection, encoded as {size_sel, byte_sel}
   typedef enum logic [1:0] {
      LANE_FULL  = 2'b00,
      LANE_HI8   = 2'b01,
      LANE_LOW2  = 2'b10,
      LANE_HIGH2 = 2'b11
   } lane_e;

   function automatic logic [BUS_W-1:0] lane_fold(input logic [BUS_W-1:0] d, input lane_e m);
      logic [BUS_W-1:0] w;
      w = '1;
      unique case (m)
         LANE_FULL:  w = d;
         LANE_HI8:   w[17:10] = d[9:2];
         LANE_HIGH2: w[11:10] = d[1:0];
         LANE_LOW2:  w[3:2]   = d[1:0];
         default:    w = '1;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
   import adc_bus_pkg::*;
#(
   parameter int unsigned CONV_CYC  = 152,
   parameter int unsigned ABORT_MIN = 15,
   parameter int unsigned ABORT_MAX = 120
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_n,
   input  logic             sel_n,
   input  logic [BUS_W-1:0] sample_in,
   output logic             busy,
   output logic [BUS_W-1:0] result
);

   localparam int unsigned CW = $clog2(CONV_CYC + 1);
   localparam logic [CW-1:0] LAST_C = CW'(CONV_CYC - 1);
   localparam logic [CW-1:0] WMIN_C = CW'(ABORT_MIN);
   localparam logic [CW-1:0] WMAX_C = CW'(ABORT_MAX);

   logic          conv_d, sel_d;
   logic [CW-1:0] cnt;
   logic [CW-1:0] elapsed;
   logic          conv_fall, sel_fall, in_win, abort_hit, done_hit;

   always_comb begin
      conv_fall = conv_d & ~conv_n;
      sel_fall  = sel_d & ~sel_n;
      elapsed   = cnt + CW'(1);
      in_win    = busy && (elapsed >= WMIN_C) && (elapsed <= WMAX_C);
      abort_hit = in_win && ((conv_fall && !sel_n) || sel_fall);
      done_hit  = busy && (cnt == LAST_C);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         conv_d <= 1'b1;
         sel_d  <= 1'b1;
         busy   <= 1'b0;
         cnt    <= '0;
         result <= '0;
      end else begin
         conv_d <= conv_n;
         sel_d  <= sel_n;
         if (!busy) begin
            if (conv_fall) begin
               busy <= 1'b1;
               cnt  <= '0;
            end
         end else if (abort_hit) begin
            busy <= 1'b0;
         end else if (done_hit) begin
            busy   <= 1'b0;
            result <= sample_in;
         end else begin
            cnt <= elapsed;
         end
      end
   end

endmodule

// File: rtl/adc_bus_fold.sv
module adc_bus_fold
   import adc_bus_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] result,
   input  logic             byte_sel,
   input  logic             size_sel,
   input  logic             sel_n,
   input  logic             rd_n,
   output logic [BUS_W-1:0] bus_q,
   output logic             bus_en
);

   lane_e            lane;
   logic [BUS_W-1:0] folded;
   logic             drive;

   always_comb begin
      lane   = lane_e'({size_sel, byte_sel});
      folded = lane_fold(result, lane);
      drive  = ~sel_n & ~rd_n;
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bus_q  <= '1;
            bus_en <= 1'b0;
         end else begin
            bus_q  <= folded;
            bus_en <= drive;
         end
      end
   end else begin : g_comb
      assign bus_q  = folded;
      assign bus_en = drive & rst_n;
   end

endmodule

// File: rtl/adc_bus_model.sv
module adc_bus_model
   import adc_bus_pkg::*;
#(
   parameter int unsigned CONV_CYC  = 152,
   parameter int unsigned ABORT_MIN = 15,
   parameter int unsigned ABORT_MAX = 120,
   parameter int unsigned MIN_PULSE = 5,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        conv_n,
   input  logic        sel_n,
   input  logic        rd_n,
   input  logic        byte_sel,
   input  logic        size_sel,
   input  logic [17:0] sample_in,
   output logic        busy,
   output logic [17:0] bus_q,
   output logic        bus_en
);

   if (CONV_CYC < 2) begin : g_bad_conv
      $error("CONV_CYC must be at least 2");
   end
   if (ABORT_MIN < 1 || ABORT_MIN > ABORT_MAX) begin : g_bad_win
      $error("abort window bounds out of order");
   end
   if (ABORT_MAX >= CONV_CYC) begin : g_bad_max
      $error("abort window must close before the conversion ends");
   end
   if (MIN_PULSE < 1) begin : g_bad_pulse
      $error("MIN_PULSE must be at least 1");
   end

   logic [BUS_W-1:0] result;

   adc_conv_ctrl #(
      .CONV_CYC (CONV_CYC),
      .ABORT_MIN(ABORT_MIN),
      .ABORT_MAX(ABORT_MAX)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .conv_n   (conv_n),
      .sel_n    (sel_n),
      .sample_in(sample_in),
      .busy     (busy),
      .result   (result)
   );

   adc_bus_fold #(
      .OUT_REG(OUT_REG)
   ) u_fold (
      .clk     (clk),
      .rst_n   (rst_n),
      .result  (result),
      .byte_sel(byte_sel),
      .size_sel(size_sel),
      .sel_n   (sel_n),
      .rd_n    (rd_n),
      .bus_q   (bus_q),
      .bus_en  (bus_en)
   );

endmodule

// File: rtl/adc_bus_model_chk.sv
module adc_bus_model_chk #(
   parameter int unsigned CONV_CYC  = 152,
   parameter int unsigned MIN_PULSE = 5,
   parameter bit          OUT_REG   = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        conv_n,
   input logic        sel_n,
   input logic        rd_n,
   input logic        byte_sel,
   input logic        size_sel,
   input logic        busy,
   input logic [17:0] bus_q,
   input logic        bus_en
);

   localparam int unsigned HW = $clog2(CONV_CYC + 2);
   localparam int unsigned LW = $clog2(MIN_PULSE + 1);

   logic [HW-1:0] hi_run;
   logic [LW-1:0] lo_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= '0;
      end else begin
         if (!busy)                         hi_run <= '0;
         else if (hi_run <= HW'(CONV_CYC))  hi_run <= hi_run + HW'(1);
         if (conv_n)                        lo_run <= '0;
         else if (lo_run < LW'(MIN_PULSE))  lo_run <= lo_run + LW'(1);
      end
   end

   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $fell(conv_n)) |=> busy); // R2
   AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (hi_run < HW'(CONV_CYC))); // R2
   AST_CONV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_n) |-> (lo_run >= LW'(MIN_PULSE))); // R2

   if (OUT_REG) begin : g_reg_chk
      AST_EN_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
         bus_en |-> $past(!rd_n && !sel_n)); // R4
      AST_HI8_ONES: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_en && $past(!size_sel && byte_sel)) |-> (bus_q[9:0] == 10'h3FF)); // R6
      AST_SIZE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_en && $past(size_sel)) |-> (bus_q[17:12] == 6'h3F && bus_q[9:4] == 6'h3F
                                          && bus_q[1:0] == 2'b11)); // R7
   end

endmodule

bind adc_bus_model adc_bus_model_chk #(
   .CONV_CYC (CONV_CYC),
   .MIN_PULSE(MIN_PULSE),
   .OUT_REG  (OUT_REG)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .conv_n  (conv_n),
   .sel_n   (sel_n),
   .rd_n    (rd_n),
   .byte_sel(byte_sel),
   .size_sel(size_sel),
   .busy    (busy),
   .bus_q   (bus_q),
   .bus_en  (bus_en)
);

// File: tb/adc_bus_model_bench.sv
`timescale 1ns/1ps
module adc_bus_model_bench;

   localparam int CONV_CYC  = 152;
   localparam int ABORT_MIN = 15;
   localparam int ABORT_MAX = 120;

   logic        clk = 1'b0;
   logic        rst_n, conv_n, sel_n, rd_n, byte_sel, size_sel;
   logic [17:0] sample_in;
   logic        busy, bus_en;
   logic [17:0] bus_q;

   int          n_chk = 0;
   int          n_fail = 0;
   logic [17:0] exp_res;

   always #2 clk = ~clk;

   adc_bus_model u_adc_bus_model (
      .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .sel_n(sel_n), .rd_n(rd_n),
      .byte_sel(byte_sel), .size_sel(size_sel), .sample_in(sample_in),
      .busy(busy), .bus_q(bus_q), .bus_en(bus_en)
   );

   function automatic logic [17:0] fold_exp(input logic [17:0] d, input logic s, input logic b);
      logic [17:0] r;
      r = {18{1'b1}};
      if (!s && !b)     r = d;
      else if (!s && b) r[17:10] = d[9:2];
      else if (s && b)  r[11:10] = d[1:0];
      else              r[3:2] = d[1:0];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // kind: 0 none, 1 conv edge with sel low, 2 sel edge, 3 conv edge with sel high
   task automatic conv_run(input logic [17:0] s_early, input logic [17:0] s_late,
                           input int kind, input int at, input string req);
      int hi;
      int expect_len;
      bit aborts;
      hi = 0;
      sel_n = (kind == 1) ? 1'b0 : 1'b1;
      sample_in = s_early;
      cyc(2);
      conv_n = 1'b0;
      aborts = (kind == 1 || kind == 2) && at >= ABORT_MIN && at <= ABORT_MAX;
      for (int i = 1; i < 400; i++) begin
         cyc(1);
         if (busy) hi++;
         if (i == 6) conv_n = 1'b1;
         if (i == CONV_CYC / 2) sample_in = s_late;
         if (kind != 0 && i == at) begin
            if (kind == 2) sel_n = 1'b0;
            else conv_n = 1'b0;
         end
         if (kind != 0 && kind != 2 && i == at + 6) conv_n = 1'b1;
         if (!busy && i > 1 && (kind == 0 || i > at + 7)) break;
      end
      conv_n = 1'b1;
      sel_n = 1'b1;
      expect_len = aborts ? at : CONV_CYC;
      chk(req, hi, expect_len);
      if (!aborts) exp_res = s_late;
      cyc(8);
   endtask

   task automatic read_chk(input logic s, input logic b, input string req);
      sel_n = 1'b0; rd_n = 1'b0; size_sel = s; byte_sel = b;
      cyc(1);
      chk({req, " R4 enable"}, bus_en, 1);
      chk(req, bus_q, fold_exp(exp_res, s, b));
   endtask

   task automatic read_end();
      rd_n = 1'b1;
      cyc(1);
      chk("R4 disable after read high", bus_en, 0);
      sel_n = 1'b1;
      cyc(1);
   endtask

   initial begin
      rst_n = 1'b0; conv_n = 1'b1; sel_n = 1'b1; rd_n = 1'b1;
      byte_sel = 1'b0; size_sel = 1'b0; sample_in = '0;
      exp_res = '0;
      void'($urandom(32'h1c4d5));
      cyc(5);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 busy", busy, 0);
      chk("R1 bus_en", bus_en, 0);
      cyc(8);
      read_chk(1'b0, 1'b0, "R1 reset result");
      read_end();

      // select without read keeps the bus disabled
      sel_n = 1'b0; cyc(2);
      chk("R4 sel only", bus_en, 0);
      sel_n = 1'b1; cyc(1);

      // full conversion, sample changed mid-way
      conv_run(18'h0AAAA, 18'h2D3C5, 0, 0, "R2 busy length");
      read_chk(1'b0, 1'b0, "R3 stored sample");
      size_sel = 1'b0; byte_sel = 1'b1; cyc(1);
      chk("R8 lane change", bus_q, fold_exp(exp_res, 1'b0, 1'b1));
      size_sel = 1'b1; byte_sel = 1'b1; cyc(1);
      chk("R8 size change", bus_q, fold_exp(exp_res, 1'b1, 1'b1));
      read_end();
      read_chk(1'b0, 1'b1, "R6 high byte fold");
      read_end();
      read_chk(1'b1, 1'b1, "R7 high two lsbs");
      read_end();
      read_chk(1'b1, 1'b0, "R7 low two lsbs");
      read_end();

      // aborts inside the window, including both bounds
      conv_run(18'h11111, 18'h22222, 1, 40, "R9 conv abort length");
      read_chk(1'b0, 1'b0, "R9 result kept");
      read_end();
      conv_run(18'h13579, 18'h3FFFF, 1, ABORT_MIN, "R9 abort at lower bound");
      conv_run(18'h0F0F0, 18'h30303, 2, 60, "R10 sel abort length");
      read_chk(1'b0, 1'b0, "R10 result kept");
      read_end();
      conv_run(18'h00001, 18'h00002, 2, ABORT_MAX, "R10 abort at upper bound");

      // edges outside the window, or with select high
      conv_run(18'h0, 18'h15A5A, 1, ABORT_MIN - 2, "R11 early edge ignored");
      read_chk(1'b0, 1'b0, "R11 early stores sample");
      read_end();
      conv_run(18'h0, 18'h2A5A5, 2, ABORT_MAX + 1, "R11 late edge ignored");
      read_chk(1'b0, 1'b0, "R11 late stores sample");
      read_end();
      conv_run(18'h0, 18'h0C3C3, 3, 50, "R12 edge with sel high ignored");
      read_chk(1'b0, 1'b0, "R12 stores sample");
      read_end();

      // random mix
      for (int k = 0; k < 16; k++) begin
         int kind;
         int at;
         kind = $urandom_range(0, 3);
         at = $urandom_range(ABORT_MIN, ABORT_MAX);
         conv_run(18'($urandom), 18'($urandom), kind, at, "R2 R9 R10 R12 random run");
         read_chk(1'($urandom), 1'($urandom), "R3 R5 R6 R7 random read");
         read_end();
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule